// File: doc/BRIEF.md
# Indirect Register Access Window

This block gives a host access to a bank of thirty-two 8-bit control registers through a single 32-bit memory-mapped word. The host cannot reach the bank registers directly. It writes the whole window word with a register index and a data byte in two fields. It commits the data by raising a strobe bit. The byte held by the indexed register is always visible in a read-only field of the same word.

A release bit in the window word holds every bank register at zero until software sets it. A system reset clears the window word, so the bank stays in reset after power-up until software releases it. The contents of the bank leave the block on a flat bus that drives the controlled circuitry.

The usual software sequences are short. To write: release the bank, place the index and the data, raise the strobe, then drop the strobe. To read: drop the strobe, place the index, then read the low byte.

Top module: `ind_reg_window`

## Requirements
- R1: While `rst_n` is low, the window word, all 32 bank registers and `win_rdata` are zero.
- R2: Bit 28 (release), bit 24 (strobe), bits 20:16 (register index) and bits 15:8 (write data) of `win_rdata` return the values from the last host write. Bits 31:29, 27:25 and 23:21 always read as zero. Host values written to bits 7:0 are ignored.
- R3: While the stored release bit is 0, all bank registers read as 0x00, strobes cause no write, and `win_rdata[7:0]` is zero.
- R4: A host write commits when four conditions hold: its bit 24 is 1, the stored strobe bit is 0, the stored release bit is already 1, and its own bit 28 is 1. The commit writes data bits 15:8 of that same word into the register selected by its bits 20:16, at the same clock edge.
- R5: A host write whose bit 24 is 1 while the stored strobe bit is already 1 leaves the bank unchanged, even when its data or index differ.
- R6: `win_rdata[7:0]` shows the contents of the register selected by the stored index, with no added cycle. In the cycle after a committing write, it already shows the new byte.
- R7: A host write with bit 28 equal to 0 clears all 32 bank registers at that edge.
- R8: A host write that sets bit 28 and raises bit 24 together, while the stored release bit is 0, writes no register.
- R9: A committed write changes only the register it selects. Register g appears on `bank_q[8*g+7:8*g]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| win_we | input | 1 | Host write enable for the window word |
| win_wdata | input | 32 | Word written into the window |
| win_rdata | output | 32 | Window word as read by the host |
| bank_q | output | 256 | Contents of the 32 bank registers, register g at bits 8g+7:8g |

## Verification
Several properties are checked on every cycle. Unused bits must stay zero. The bank must stay zero while it is held. An idle host cycle must change nothing. A held strobe must never write, and a rising strobe must land its byte at the indexed register. The bench scenarios cover the behaviour that needs history and sequences. These include rewriting the index to read back several registers, releasing and strobing in the same word, clearing release after data has been stored, and isolating one register from its neighbours across long random runs.

// File: rtl/ind_reg_window.sv
module ind_reg_window (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         win_we,
  input  logic [31:0]  win_wdata,
  output logic [31:0]  win_rdata,
  output logic [255:0] bank_q
);
  localparam int AW       = 5;
  localparam int DW       = 8;
  localparam int NREG     = 1 << AW;
  localparam int REL_BIT  = 28;
  localparam int STB_BIT  = 24;
  localparam int IDX_LSB  = 16;
  localparam int DIN_LSB  = 8;

  logic          rel_q, stb_q;
  logic [AW-1:0] idx_q;
  logic [DW-1:0] din_q;
  logic [DW-1:0] bank [NREG];

  logic          rel_next;
  logic          commit;
  logic [AW-1:0] w_idx;
  logic [DW-1:0] w_din;

  assign rel_next = win_we ? win_wdata[REL_BIT] : rel_q;
  assign w_idx    = win_wdata[IDX_LSB +: AW];
  assign w_din    = win_wdata[DIN_LSB +: DW];
  assign commit   = win_we & win_wdata[STB_BIT] & ~stb_q & rel_q & win_wdata[REL_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rel_q <= 1'b0;
      stb_q <= 1'b0;
      idx_q <= '0;
      din_q <= '0;
    end else if (win_we) begin
      rel_q <= win_wdata[REL_BIT];
      stb_q <= win_wdata[STB_BIT];
      idx_q <= w_idx;
      din_q <= w_din;
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n || !rel_next)
        bank[g] <= '0;
      else if (commit && w_idx == AW'(g))
        bank[g] <= w_din;
    end
    assign bank_q[g*DW +: DW] = bank[g];
  end

  always_comb begin
    win_rdata                   = '0;
    win_rdata[REL_BIT]          = rel_q;
    win_rdata[STB_BIT]          = stb_q;
    win_rdata[IDX_LSB +: AW]    = idx_q;
    win_rdata[DIN_LSB +: DW]    = din_q;
    win_rdata[DW-1:0]           = rel_q ? bank[idx_q] : '0;
  end
endmodule

module ind_reg_window_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         win_we,
  input logic [31:0]  win_wdata,
  input logic [31:0]  win_rdata,
  input logic [255:0] bank_q
);
  // R1
  rst_clear_chk: assert property (@(posedge clk) $rose(rst_n) |-> (win_rdata == 32'h0 && bank_q == '0));

  // R2
  unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_rdata[31:29] == 3'b0 && win_rdata[27:25] == 3'b0 && win_rdata[23:21] == 3'b0));

  // R3
  held_bank_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !win_rdata[28] |-> (bank_q == '0 && win_rdata[7:0] == 8'h0));

  // R4
  commit_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_we && win_wdata[24] && win_wdata[28] && !win_rdata[24] && win_rdata[28])
    |=> bank_q[$past(win_wdata[20:16])*8 +: 8] == $past(win_wdata[15:8]));

  // R5
  held_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_we && win_wdata[24] && win_wdata[28] && win_rdata[24]) |=> $stable(bank_q));

  // R2
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !win_we |=> ($stable(bank_q) && $stable(win_rdata)));

  // R8
  release_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_we && !win_rdata[28]) |=> bank_q == '0);
endmodule

bind ind_reg_window ind_reg_window_chk u_chk (.*);

// File: tb/tb_ind_reg_window.sv
`timescale 1ns/1ps
module tb_ind_reg_window;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         win_we = 1'b0;
  logic [31:0]  win_wdata = '0;
  logic [31:0]  win_rdata;
  logic [255:0] bank_q;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  logic [7:0]  m_bank [32];
  logic [31:0] m_win;

  localparam logic [31:0] WMASK = 32'h111F_FF00;

  always #2 clk = ~clk;

  ind_reg_window dut (.*);

  function automatic logic [31:0] exp_rdata();
    logic [31:0] r = m_win;
    if (m_win[28]) r[7:0] = m_bank[m_win[20:16]];
    return r;
  endfunction

  function automatic logic [255:0] exp_bank();
    logic [255:0] b;
    for (int i = 0; i < 32; i++) b[i*8 +: 8] = m_bank[i];
    return b;
  endfunction

  function automatic void model_write(logic [31:0] w);
    logic c = w[24] & ~m_win[24] & m_win[28] & w[28];
    if (!w[28]) begin
      for (int i = 0; i < 32; i++) m_bank[i] = 8'h0;
    end else if (c) begin
      m_bank[w[20:16]] = w[15:8];
    end
    m_win = w & WMASK;
  endfunction

  task automatic check(string tag);
    tests++;
    if (win_rdata !== exp_rdata()) begin
      fails++;
      $display("FAIL %s win_rdata actual=%h expected=%h", tag, win_rdata, exp_rdata());
    end
    tests++;
    if (bank_q !== exp_bank()) begin
      fails++;
      $display("FAIL %s bank_q actual=%h expected=%h", tag, bank_q, exp_bank());
    end
  endtask

  task automatic host_write(logic [31:0] w);
    @(negedge clk);
    win_we = 1'b1;
    win_wdata = w;
    @(negedge clk);
    win_we = 1'b0;
    win_wdata = $urandom;
    model_write(w);
  endtask

  function automatic logic [31:0] mk(bit rel, bit stb, logic [4:0] idx, logic [7:0] d);
    return {3'b0, rel, 3'b0, stb, 3'b0, idx, d, 8'h0};
  endfunction

  task automatic wr_reg(logic [4:0] idx, logic [7:0] d);
    host_write(mk(1, 0, idx, d));
    host_write(mk(1, 1, idx, d));
    host_write(mk(1, 0, idx, d));
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m_win = '0;
    for (int i = 0; i < 32; i++) m_bank[i] = 8'h0;
    win_wdata = 32'hFFFF_FFFF;
    win_we = 1'b1;
    repeat (3) @(negedge clk);
    check("R1");
    win_we = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check("R1");

    // R3: strobe while held does nothing
    host_write(mk(0, 0, 5'd3, 8'hA5));
    host_write(mk(0, 1, 5'd3, 8'hA5));
    check("R3");

    // R8: release and strobe in one word
    host_write(mk(0, 0, 5'd4, 8'h11));
    host_write(mk(1, 1, 5'd4, 8'h11));
    check("R8");
    host_write(mk(1, 0, 5'd4, 8'h11));

    // R4 R6: commit and immediate read
    host_write(mk(1, 1, 5'd4, 8'h3C));
    check("R6");
    check("R4");

    // R5: held strobe, changing data
    host_write(mk(1, 1, 5'd4, 8'hEE));
    host_write(mk(1, 1, 5'd9, 8'h77));
    check("R5");

    // R2: host low byte ignored, unused bits zero
    host_write(32'hFFFF_FFFF & ~32'h0100_0000);
    check("R2");

    // R9: neighbours and boundary indices
    wr_reg(5'd0, 8'h01);
    wr_reg(5'd31, 8'hFE);
    wr_reg(5'd1, 8'h80);
    check("R9");
    host_write(mk(1, 0, 5'd31, 8'h00));
    check("R6");
    host_write(mk(1, 0, 5'd0, 8'h00));
    check("R6");

    // R7: clearing release wipes the bank
    host_write(mk(0, 0, 5'd31, 8'h00));
    check("R7");
    host_write(mk(1, 0, 5'd31, 8'h00));
    check("R7");

    for (int n = 0; n < 600; n++) begin
      logic [31:0] w = $urandom;
      w[28] = ($urandom % 16) != 0;
      w[24] = $urandom % 2;
      host_write(w);
      check("R4 R5 R6 R9 random");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule